// File: doc/BRIEF.md
# Codec Power-Control Register with ADC Warm-Up Sequencer

This block holds the power-enable register of an audio codec. It sits behind a simple register write and read port. It drives one enable line to each of seven sub-blocks: the ADC, the microphone path, the DAC, the mono line output, the speaker, the beep input and the common reference. An active-low hardware power-down pin overrides every enable line. The register contents are not changed by that pin.

A three-state sequencer (`WU_OFF`, `WU_COUNT`, `WU_DONE`) holds the ADC output invalid for a fixed number of sample-rate strobes after the ADC is switched on.
- `WU_OFF` moves to `WU_COUNT` when the ADC is enabled and the pin is high.
- `WU_COUNT` moves to `WU_DONE` on the strobe that completes the count.
- `WU_COUNT` and `WU_DONE` both return to `WU_OFF` when the ADC is disabled or the pin goes low.

The block also has these functions:
- The reference enable can only be cleared when nothing else needs it.
- A one-cycle strobe resets the external input-gain register when every power source is off.
- A flag tells the clock generator when sample clocks must run.
- Two beep routing selects pass straight through.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset the following are all 0: every enable output, `rdata`, `adc_ready` and `gain_rst`.
- R2: A write with `addr`=0 stores `wdata` bits as follows: bit0 ADC, bit1 mic, bit2 DAC, bit3 line-out, bit4 speaker, bit5 beep, bit6 reference. A read of address 0 returns these bits in `rdata` one cycle after `rd_en`, and `rdata[7]` is always 0.
- R3: A write to any nonzero address changes nothing. A read of a nonzero address returns 0.
- R4: While `pdn_n` is 0, every enable output is 0. The register keeps its value and reappears on the outputs when `pdn_n` returns to 1.
- R5: `adc_ready` is 0 while the ADC is disabled. After the ADC is enabled, it rises only on the clock edge that samples the `WARMUP`-th `fs_tick` (default 1059) counted in `WU_COUNT`.
- R6: Disabling the ADC or pulling `pdn_n` low during the warm-up discards the count. The next warm-up again needs the full `WARMUP` strobes.
- R7: Writing bit6=0 clears the reference enable only when all of the following are 0: `pll_en`, `mclk_out_en` and `wdata[5:0]`. Otherwise bit6 stays 1.
- R8: `gain_rst` is high for exactly one cycle, in the first cycle in which `pll_en`, `mclk_out_en` and register bits 6:0 are all 0. It does not pulse out of reset.
- R9: `clk_req` is 1 whenever the ADC or DAC enable output is 1, or when `lvl1_active` or `lvl2_active` is 1. Otherwise it is 0.
- R10: `beep_spk_route_o` and `beep_line_route_o` equal their inputs at all times, whatever the beep enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pdn_n | input | 1 | Active-low hardware power-down |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after rd_en |
| pll_en | input | 1 | PLL enable state from another register |
| mclk_out_en | input | 1 | Master-clock output enable state |
| lvl1_active | input | 1 | First level-control function active |
| lvl2_active | input | 1 | Second level-control function active |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| beep_spk_route_i | input | 1 | Beep-to-speaker route select |
| beep_line_route_i | input | 1 | Beep-to-line-out route select |
| beep_spk_route_o | output | 1 | Passed-through speaker route select |
| beep_line_route_o | output | 1 | Passed-through line-out route select |
| en_adc | output | 1 | ADC power enable |
| en_mic | output | 1 | Microphone path power enable |
| en_dac | output | 1 | DAC power enable |
| en_line | output | 1 | Mono line-out power enable |
| en_spk | output | 1 | Speaker power enable |
| en_beep | output | 1 | Beep input power enable |
| en_ref | output | 1 | Common reference power enable |
| adc_ready | output | 1 | ADC data valid (warm-up complete) |
| clk_req | output | 1 | Sample clocks are required |
| gain_rst | output | 1 | One-cycle reset strobe for the gain register |

## Verification
The properties assume the following about the inputs:
- `fs_tick`, `pll_en` and `mclk_out_en` are synchronous to `clk`.
- `pdn_n` changes only between edges.
- Nothing moves during reset.

The bench drives every input on the falling edge, so each value is stable at the rising edge that samples it. The random phase holds `fs_tick` low, so that warm-up progress comes only from the directed tick sequences. Inside those sequences, ticks are applied only once the sequencer has had a full cycle to leave `WU_OFF`.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
    localparam int NUM_EN   = 7;
    localparam int B_ADC    = 0;
    localparam int B_MIC    = 1;
    localparam int B_DAC    = 2;
    localparam int B_LINE   = 3;
    localparam int B_SPK    = 4;
    localparam int B_BEEP   = 5;
    localparam int B_REF    = 6;

    typedef enum logic [1:0] {
        WU_OFF   = 2'd0,
        WU_COUNT = 2'd1,
        WU_DONE  = 2'd2
    } wu_state_t;
endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
    import codec_pwr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pll_en,
    input  logic              mclk_out_en,
    output logic [NUM_EN-1:0] ctl,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - NUM_EN;

    logic              hit;
    logic              ref_may_clear;
    logic [NUM_EN-1:0] ctl_next;

    assign hit = (addr == ADDR_W'(REG_ADDR));

    // The reference bit may fall only when nothing else keeps it needed.
    assign ref_may_clear = (wdata[B_REF-1:0] == '0) && !pll_en && !mclk_out_en;

    always_comb begin
        ctl_next = ctl;
        if (wr_en && hit) begin
            ctl_next[B_REF-1:0] = wdata[B_REF-1:0];
            ctl_next[B_REF]     = wdata[B_REF] | (ctl[B_REF] & !ref_may_clear);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl   <= '0;
            rdata <= '0;
        end else begin
            ctl <= ctl_next;
            if (rd_en) begin
                rdata <= hit ? {{PAD_W{1'b0}}, ctl} : '0;
            end
        end
    end
endmodule

// File: rtl/adc_warmup.sv
module adc_warmup
    import codec_pwr_pkg::*;
#(
    parameter int WARMUP = 1059
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_on,
    input  logic fs_tick,
    output logic ready
);
    localparam int CNT_W = (WARMUP > 1) ? $clog2(WARMUP) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WARMUP - 1);

    wu_state_t        state, state_next;
    logic [CNT_W-1:0] cnt, cnt_next;

    always_comb begin
        state_next = state;
        cnt_next   = cnt;
        unique case (state)
            WU_OFF: begin
                cnt_next = '0;
                if (adc_on) state_next = WU_COUNT;
            end
            WU_COUNT: begin
                if (!adc_on) begin
                    state_next = WU_OFF;
                    cnt_next   = '0;
                end else if (fs_tick) begin
                    if (cnt == LAST) state_next = WU_DONE;
                    else             cnt_next   = cnt + 1'b1;
                end
            end
            WU_DONE: begin
                if (!adc_on) begin
                    state_next = WU_OFF;
                    cnt_next   = '0;
                end
            end
            default: begin
                state_next = WU_OFF;
                cnt_next   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WU_OFF;
            cnt   <= '0;
        end else begin
            state <= state_next;
            cnt   <= cnt_next;
        end
    end

    always_comb begin
        ready = (state == WU_DONE);
    end
endmodule

// File: rtl/alloff_strobe.sv
module alloff_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic all_off,
    output logic pulse
);
    logic all_off_q;

    // Starts at 1 so that the reset state itself gives no strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) all_off_q <= 1'b1;
        else        all_off_q <= all_off;
    end

    assign pulse = all_off & !all_off_q;
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
    import codec_pwr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int REG_ADDR = 0,
    parameter int WARMUP   = 1059
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pll_en,
    input  logic              mclk_out_en,
    input  logic              lvl1_active,
    input  logic              lvl2_active,
    input  logic              fs_tick,
    input  logic              beep_spk_route_i,
    input  logic              beep_line_route_i,
    output logic              beep_spk_route_o,
    output logic              beep_line_route_o,
    output logic              en_adc,
    output logic              en_mic,
    output logic              en_dac,
    output logic              en_line,
    output logic              en_spk,
    output logic              en_beep,
    output logic              en_ref,
    output logic              adc_ready,
    output logic              clk_req,
    output logic              gain_rst
);
    logic [NUM_EN-1:0] ctl;
    logic [NUM_EN-1:0] en_vec;
    logic              all_off;

    pwr_ctl_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .pll_en      (pll_en),
        .mclk_out_en (mclk_out_en),
        .ctl         (ctl),
        .rdata       (rdata)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EN; gi++) begin : g_gate
            assign en_vec[gi] = ctl[gi] & pdn_n;
        end
    endgenerate

    assign en_adc  = en_vec[B_ADC];
    assign en_mic  = en_vec[B_MIC];
    assign en_dac  = en_vec[B_DAC];
    assign en_line = en_vec[B_LINE];
    assign en_spk  = en_vec[B_SPK];
    assign en_beep = en_vec[B_BEEP];
    assign en_ref  = en_vec[B_REF];

    adc_warmup #(.WARMUP(WARMUP)) u_warm (
        .clk     (clk),
        .rst_n   (rst_n),
        .adc_on  (en_vec[B_ADC]),
        .fs_tick (fs_tick),
        .ready   (adc_ready)
    );

    assign all_off = (ctl == '0) && !pll_en && !mclk_out_en;

    alloff_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .all_off (all_off),
        .pulse   (gain_rst)
    );

    assign clk_req = en_vec[B_ADC] | en_vec[B_DAC] | lvl1_active | lvl2_active;

    assign beep_spk_route_o  = beep_spk_route_i;
    assign beep_line_route_o = beep_line_route_i;
endmodule

module codec_pwr_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pdn_n,
    input logic              pll_en,
    input logic              mclk_out_en,
    input logic              fs_tick,
    input logic [DATA_W-1:0] rdata,
    input logic              en_adc,
    input logic              en_mic,
    input logic              en_dac,
    input logic              en_line,
    input logic              en_spk,
    input logic              en_beep,
    input logic              en_ref,
    input logic              adc_ready,
    input logic              clk_req,
    input logic              gain_rst
);
    // R4
    pdn_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |-> !(en_adc | en_mic | en_dac | en_line | en_spk | en_beep | en_ref));

    // R2
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1] == 1'b0);

    // R5
    ready_needs_adc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_ready |-> $past(en_adc));

    // R5
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_ready) |-> $past(fs_tick));

    // R7
    ref_clear_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_n && $past(pdn_n) && $fell(en_ref)) |->
        (!(en_adc | en_mic | en_dac | en_line | en_spk | en_beep)
         && !$past(pll_en) && !$past(mclk_out_en)));

    // R8
    gain_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_rst |=> !gain_rst);

    // R9
    clk_req_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_adc | en_dac) |-> clk_req);
endmodule

bind codec_pwr_ctrl codec_pwr_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pdn_n       (pdn_n),
    .pll_en      (pll_en),
    .mclk_out_en (mclk_out_en),
    .fs_tick     (fs_tick),
    .rdata       (rdata),
    .en_adc      (en_adc),
    .en_mic      (en_mic),
    .en_dac      (en_dac),
    .en_line     (en_line),
    .en_spk      (en_spk),
    .en_beep     (en_beep),
    .en_ref      (en_ref),
    .adc_ready   (adc_ready),
    .clk_req     (clk_req),
    .gain_rst    (gain_rst)
);

// File: tb/codec_pwr_ctrl_test.sv
module codec_pwr_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WARM = 1059;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdn_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pll_en = 1'b0;
    logic       mclk_out_en = 1'b0;
    logic       lvl1_active = 1'b0;
    logic       lvl2_active = 1'b0;
    logic       fs_tick = 1'b0;
    logic       rs_i = 1'b0;
    logic       rl_i = 1'b0;
    logic       rs_o, rl_o;
    logic       en_adc, en_mic, en_dac, en_line, en_spk, en_beep, en_ref;
    logic       adc_ready, clk_req, gain_rst;

    int checks = 0;
    int failures = 0;
    logic [6:0] mdl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_pwr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pll_en(pll_en),
        .mclk_out_en(mclk_out_en), .lvl1_active(lvl1_active),
        .lvl2_active(lvl2_active), .fs_tick(fs_tick),
        .beep_spk_route_i(rs_i), .beep_line_route_i(rl_i),
        .beep_spk_route_o(rs_o), .beep_line_route_o(rl_o),
        .en_adc(en_adc), .en_mic(en_mic), .en_dac(en_dac), .en_line(en_line),
        .en_spk(en_spk), .en_beep(en_beep), .en_ref(en_ref),
        .adc_ready(adc_ready), .clk_req(clk_req), .gain_rst(gain_rst)
    );

    function automatic logic [6:0] next_reg(logic [6:0] cur, logic [7:0] d,
                                            logic pll, logic mck);
        logic [6:0] n;
        n[5:0] = d[5:0];
        n[6]   = d[6] | (cur[6] & !((d[5:0] == 0) && !pll && !mck));
        return n;
    endfunction

    function automatic logic alloff(logic [6:0] r, logic pll, logic mck);
        return (r == 0) && !pll && !mck;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] en_now();
        return {en_ref, en_beep, en_spk, en_line, en_dac, en_mic, en_adc};
    endfunction

    // One clock with a write; checks outputs after the edge.
    task automatic step_wr(logic [7:0] a, logic [7:0] d, logic pll, logic mck,
                           logic pdn, logic l1, logic l2);
        logic [6:0] old;
        logic       exp_g;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; pll_en = pll; mclk_out_en = mck;
        pdn_n = pdn; lvl1_active = l1; lvl2_active = l2;
        old = mdl;
        if (a == 8'h00) mdl = next_reg(mdl, d, pll, mck);
        exp_g = alloff(mdl, pll, mck) & !alloff(old, pll, mck);
        @(posedge clk); #1;
        check(a == 0 ? "R2 enables" : "R3 enables",
              en_now(), pdn ? mdl : 7'h00);
        if (!pdn) check("R4 forced off", en_now(), 7'h00);
        check("R8 gain_rst", gain_rst, exp_g);
        check("R9 clk_req", clk_req, (pdn & (mdl[0] | mdl[2])) | l1 | l2);
        wr_en = 1'b0;
    endtask

    task automatic step_rd(logic [7:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        check(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fs_tick = 1'b1;
            @(negedge clk); fs_tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 enables", en_now(), 7'h00);
        check("R1 rdata", rdata, 8'h00);
        check("R1 adc_ready", adc_ready, 1'b0);
        check("R1 gain_rst", gain_rst, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        idle();
        check("R8 no pulse after reset", gain_rst, 1'b0);

        // R2 bit map and bit7
        step_wr(8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        step_rd(8'h00, 8'h7F, "R2 readback bit7");
        step_wr(8'h00, 8'h44, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        step_rd(8'h00, 8'h44, "R2 readback");
        check("R2 dac only", {en_dac, en_adc}, 2'b10);

        // R3 other address ignored
        step_wr(8'h05, 8'h3B, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        step_rd(8'h00, 8'h44, "R3 write ignored");
        step_rd(8'h01, 8'h00, "R3 read other");

        // R4 pdn keeps register
        step_wr(8'h09, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step_rd(8'h00, 8'h44, "R4 register kept");
        step_wr(8'h09, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 restored", en_now(), 7'h44);

        // R7 reference clear rule
        step_wr(8'h00, 8'h40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        step_wr(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 kept by pll", en_ref, 1'b1);
        step_wr(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 kept by mclk", en_ref, 1'b1);
        step_wr(8'h00, 8'h20, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 kept by beep", en_ref, 1'b1);
        step_wr(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 cleared", en_ref, 1'b0);
        check("R8 pulse on all-off", gain_rst, 1'b1);
        idle();
        check("R8 pulse one cycle", gain_rst, 1'b0);

        // R10 route pass-through with beep enable off and on
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rs_i = i[0]; rl_i = i[1];
            #1 check("R10 routes", {rl_o, rs_o}, i[1:0]);
        end
        step_wr(8'h00, 8'h60, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk); rs_i = 1'b0; rl_i = 1'b1;
        #1 check("R10 routes beep on", {rl_o, rs_o}, 2'b10);

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, d;
            a = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
            d = 8'($urandom);
            if ($urandom % 3 == 0) d[5:0] = 6'h00;
            step_wr(a, d, ($urandom % 3) == 0, ($urandom % 4) == 0,
                    ($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 6) == 0);
            if (i % 16 == 0) step_rd(8'h00, {1'b0, mdl}, "R2 random readback");
        end

        // R5 warm-up
        step_wr(8'h00, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        check("R5 off not ready", adc_ready, 1'b0);
        step_wr(8'h00, 8'h41, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        ticks(WARM - 1);
        @(posedge clk); #1;
        check("R5 not ready early", adc_ready, 1'b0);
        ticks(1);
        check("R5 ready", adc_ready, 1'b1);
        step_wr(8'h00, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        check("R5 drop on disable", adc_ready, 1'b0);

        // R6 restart after pdn during warm-up
        step_wr(8'h00, 8'h41, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        ticks(600);
        step_wr(8'h07, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step_wr(8'h07, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        ticks(WARM - 1);
        check("R6 restart pdn", adc_ready, 1'b0);
        ticks(1);
        check("R6 ready after restart", adc_ready, 1'b1);

        // R6 restart after disable during warm-up
        step_wr(8'h00, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        step_wr(8'h00, 8'h41, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        ticks(700);
        step_wr(8'h00, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        step_wr(8'h00, 8'h41, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        ticks(WARM - 1);
        check("R6 restart disable", adc_ready, 1'b0);
        ticks(1);
        check("R6 ready again", adc_ready, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule